// File: doc/BRIEF.md
# Mesh Route Unit with Fault Detour

This block makes the routing decision for one input port of a wormhole router in a two-dimensional mesh. When a packet's first flit arrives, the block picks one of five outputs from three things: the router's own coordinates, the destination coordinates carried by that flit, and a 4-bit contour code. It then keeps that output for every later flit until the last flit of the packet has passed.

The contour code says where a dead neighbouring router sits relative to this one. With the code for a healthy neighbourhood, the block routes in X-first dimension order. With any other code, a fixed set of overrides steers packets around the hole. The overrides depend only on the code and on small coordinate comparisons, so the logic does not grow with the size of the mesh. Because a detour can turn a packet from a vertical input onto a horizontal output, the block may select any output for any destination.

Flits pass straight through with valid/ready handshaking. The block only adds the one-hot output selection. The code register is written through a write-enable port. Flits of a packet already under way keep the output they locked, so a new code first affects the next packet.

Top module: `mesh_detour_route`

## Requirements
- R1: After reset the stored code is the healthy code and no packet is in progress, so a first flit addressed to the router's own coordinates selects LOCAL. The output select is one-hot, with bit 0 LOCAL, bit 1 NORTH, bit 2 SOUTH, bit 3 EAST and bit 4 WEST. out_valid equals in_valid, and in_ready equals out_ready.
- R2: Code values are healthy=0, N-of=1, S-of=2, E-of=3, W-of=4, NE-of=5, NW-of=6, SE-of=7, SW-of=8. With code 0 the route is X-first. EAST is chosen if the destination X is larger, WEST if it is smaller. Otherwise NORTH is chosen if the destination Y is larger and SOUTH if it is smaller. LOCAL is chosen when both coordinates match.
- R3: If the destination X is larger, the output is EAST for codes 0, 3, 5, 7 and 2.
- R4: If the destination X is smaller, the output is WEST for codes 0, 1, 6, 4, 8 and 2.
- R5: With code 4 and a larger destination X, the output is NORTH when the local row is 0 or the destination row is above the local row. Otherwise it is SOUTH.
- R6: With equal X and a larger destination Y, the output is NORTH unless the code is 2. With code 2 it is WEST when the local column is non-zero, and EAST otherwise.
- R7: With equal X and a smaller destination Y, the output is SOUTH unless the code is 1. With code 1 it is WEST when the local column is non-zero, and EAST otherwise.
- R8: Codes 9 to 15 route exactly like code 0.
- R9: A first flit that is accepted (valid and ready) without the last-flit marker locks its output. Every later flit, including the last one, gets that output whatever destination bits it carries. A stall or a valid gap does not end the lock.
- R10: A flit with both the first and last markers set is routed by itself and leaves no lock behind. The next first flit is routed afresh.
- R11: A code write lands at the next clock edge. A write during a packet does not change that packet's output. The new code governs the next first flit.
- R12: The remaining detours are as follows. With a larger destination X: code 1 gives EAST if dy>=ly, dx>lx+1 or lx=0, and WEST otherwise. Code 6 gives EAST if dy>=ly or dx>lx+2, and SOUTH otherwise. Code 8 gives EAST if dy<=ly or dx>lx+1, and NORTH otherwise. With a smaller destination X: code 5 gives WEST if dx<lx-1 or dy>=ly, and SOUTH otherwise. Code 7 gives NORTH if dx=lx-1 and dy>ly, and WEST otherwise. Code 3 gives NORTH if ly=0, or if lx=1 and dy>ly, and SOUTH otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the contour code |
| cfg_code | input | 4 | Contour code to store |
| loc_x | input | XW | Column of this router |
| loc_y | input | YW | Row of this router |
| in_valid | input | 1 | Upstream flit valid |
| in_head | input | 1 | Flit is the first of its packet |
| in_tail | input | 1 | Flit is the last of its packet |
| in_dest_x | input | XW | Destination column (meaningful on first flit) |
| in_dest_y | input | YW | Destination row (meaningful on first flit) |
| in_ready | output | 1 | Upstream may advance |
| out_valid | output | 1 | Flit presented to the switch |
| out_ready | input | 1 | Switch accepts the flit |
| out_sel | output | 5 | One-hot output port selection |

## Verification
The assertions assume well-formed packets. A first flit arrives only when no packet is in progress, and every packet ends with a flit carrying the last-flit marker. Only then do the lock-stability and fresh-route properties apply to the right cycles. The stimulus keeps to this framing in every sequence, including stalls and valid gaps inside a packet, and it changes the destination bits on later flits only to show that they are ignored. The sweep covers local and destination coordinates 0 to 3 under all sixteen codes. The local coordinates are held static during each packet, as the block expects of a router's own position.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  localparam int NPORT = 5;

  typedef enum logic [3:0] {
    CODE_NORMAL = 4'd0,
    CODE_N      = 4'd1,
    CODE_S      = 4'd2,
    CODE_E      = 4'd3,
    CODE_W      = 4'd4,
    CODE_NE     = 4'd5,
    CODE_NW     = 4'd6,
    CODE_SE     = 4'd7,
    CODE_SW     = 4'd8
  } contour_e;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // Unused code points fall back to the healthy code.
  function automatic contour_e clean_code(input logic [3:0] raw);
    if (raw > 4'd8) return CODE_NORMAL;
    return contour_e'(raw);
  endfunction

  function automatic logic [NPORT-1:0] port_onehot(input port_e p);
    return NPORT'(1) << p;
  endfunction

endpackage

// File: rtl/mdr_cfg_reg.sv
module mdr_cfg_reg
  import mdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_code,
  output contour_e   code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= CODE_NORMAL;
    else if (cfg_we) code_q <= clean_code(cfg_code);
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(code_q));

  // R8
  cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_code > 4'd8) |=> code_q == CODE_NORMAL);

endmodule

// File: rtl/mdr_route_calc.sv
module mdr_route_calc
  import mdr_pkg::*;
#(
  parameter int XW = 4,
  parameter int YW = 4
) (
  input  contour_e          code,
  input  logic [XW-1:0]     loc_x,
  input  logic [YW-1:0]     loc_y,
  input  logic [XW-1:0]     dest_x,
  input  logic [YW-1:0]     dest_y,
  output port_e             port
);

  localparam int CW = ((XW > YW) ? XW : YW) + 2;

  logic [CW-1:0] lx, ly, dx, dy;
  assign lx = CW'(loc_x);
  assign ly = CW'(loc_y);
  assign dx = CW'(dest_x);
  assign dy = CW'(dest_y);

  function automatic port_e side_step(input logic [CW-1:0] col);
    return (col != '0) ? PORT_WEST : PORT_EAST;
  endfunction

  always_comb begin
    port = PORT_LOCAL;
    if (dx > lx) begin
      case (code)
        CODE_N:  port = (dy >= ly || dx > lx + CW'(1) || lx == '0) ? PORT_EAST : PORT_WEST;
        CODE_NW: port = (dy >= ly || dx > lx + CW'(2)) ? PORT_EAST : PORT_SOUTH;
        CODE_W:  port = (ly == '0 || dy > ly) ? PORT_NORTH : PORT_SOUTH;
        CODE_SW: port = (dy <= ly || dx > lx + CW'(1)) ? PORT_EAST : PORT_NORTH;
        default: port = PORT_EAST;
      endcase
    end else if (dx < lx) begin
      case (code)
        CODE_NE: port = (dx + CW'(1) < lx || dy >= ly) ? PORT_WEST : PORT_SOUTH;
        CODE_SE: port = (dx + CW'(1) == lx && dy > ly) ? PORT_NORTH : PORT_WEST;
        CODE_E:  port = (ly == '0 || (lx == CW'(1) && dy > ly)) ? PORT_NORTH : PORT_SOUTH;
        default: port = PORT_WEST;
      endcase
    end else if (dy > ly) begin
      port = (code == CODE_S) ? side_step(lx) : PORT_NORTH;
    end else if (dy < ly) begin
      port = (code == CODE_N) ? side_step(lx) : PORT_SOUTH;
    end
  end

endmodule

// File: rtl/mdr_port_lock.sv
module mdr_port_lock
  import mdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flit_fire,
  input  logic             in_valid,
  input  logic             in_head,
  input  logic             in_tail,
  input  port_e            fresh_port,
  output logic             in_flight,
  output logic [NPORT-1:0] sel
);

  port_e lock_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
      lock_port <= PORT_LOCAL;
    end else if (flit_fire) begin
      if (in_tail) begin
        in_flight <= 1'b0;
      end else if (!in_flight && in_head) begin
        in_flight <= 1'b1;
        lock_port <= fresh_port;
      end
    end
  end

  assign sel = port_onehot(in_flight ? lock_port : fresh_port);

  // R9
  body_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_fire && !in_tail |=> (!(in_valid && !in_head) || sel == $past(sel)));

  // R10
  tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_fire && in_tail |=> !in_flight);

endmodule

// File: rtl/mesh_detour_route.sv
module mesh_detour_route
  import mdr_pkg::*;
#(
  parameter int XW = 4,
  parameter int YW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_code,
  input  logic [XW-1:0] loc_x,
  input  logic [YW-1:0] loc_y,
  input  logic          in_valid,
  input  logic          in_head,
  input  logic          in_tail,
  input  logic [XW-1:0] in_dest_x,
  input  logic [YW-1:0] in_dest_y,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [4:0]    out_sel
);

  contour_e         code_q;
  port_e            fresh_port;
  logic             flit_fire;
  logic             in_flight;
  logic [NPORT-1:0] sel;

  assign flit_fire = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_sel   = sel;

  mdr_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_code (cfg_code),
    .code_q   (code_q)
  );

  mdr_route_calc #(.XW(XW), .YW(YW)) u_calc (
    .code   (code_q),
    .loc_x  (loc_x),
    .loc_y  (loc_y),
    .dest_x (in_dest_x),
    .dest_y (in_dest_y),
    .port   (fresh_port)
  );

  mdr_port_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_fire  (flit_fire),
    .in_valid   (in_valid),
    .in_head    (in_head),
    .in_tail    (in_tail),
    .fresh_port (fresh_port),
    .in_flight  (in_flight),
    .sel        (sel)
  );

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_sel) == 1);

  // R2
  healthy_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_head && !in_flight && code_q == CODE_NORMAL && in_dest_x > loc_x
      |-> out_sel == 5'b01000);

  // R6
  vert_north_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_head && !in_flight && code_q != CODE_S
      && in_dest_x == loc_x && in_dest_y > loc_y
      |-> out_sel == 5'b00010);

endmodule

// File: tb/test_mesh_detour_route.sv
module test_mesh_detour_route;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_code = '0;
  logic [3:0] loc_x = '0, loc_y = '0;
  logic       in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0;
  logic [3:0] in_dest_x = '0, in_dest_y = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid;
  logic [4:0] out_sel;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model state
  int  m_cfg    = 0;
  bit  m_flight = 0;
  int  m_lock   = 0;

  always #5 clk = ~clk;

  mesh_detour_route #(.XW(4), .YW(4)) i_mesh_detour_route (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .loc_x(loc_x), .loc_y(loc_y), .in_valid(in_valid), .in_head(in_head),
    .in_tail(in_tail), .in_dest_x(in_dest_x), .in_dest_y(in_dest_y),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_sel(out_sel)
  );

  // Ports: 0 LOCAL, 1 NORTH, 2 SOUTH, 3 EAST, 4 WEST
  function automatic int ref_route(int code, int lx, int ly, int dx, int dy);
    int  c;
    bit  east;
    c = (code > 8) ? 0 : code;
    if (dx == lx) begin
      if (dy == ly) return 0;
      if (dy > ly)  return (c == 2) ? ((lx != 0) ? 4 : 3) : 1;
      return (c == 1) ? ((lx != 0) ? 4 : 3) : 2;
    end
    east = (dx > lx);
    case (c)
      1:       return east ? ((dy >= ly || dx > lx + 1 || lx == 0) ? 3 : 4) : 4;
      3:       return east ? 3 : ((ly == 0 || (lx == 1 && dy > ly)) ? 1 : 2);
      4:       return east ? ((ly == 0 || dy > ly) ? 1 : 2) : 4;
      5:       return east ? 3 : ((dx < lx - 1 || dy >= ly) ? 4 : 2);
      6:       return east ? ((dy >= ly || dx > lx + 2) ? 3 : 2) : 4;
      7:       return east ? 3 : ((dx == lx - 1 && dy > ly) ? 1 : 4);
      8:       return east ? ((dy <= ly || dx > lx + 1) ? 3 : 1) : 4;
      default: return east ? 3 : 4;
    endcase
  endfunction

  function automatic string sweep_tag(int code, int lx, int ly, int dx, int dy);
    if (code > 8) return "R8";
    if (dx == lx) return (dy > ly) ? "R6" : ((dy < ly) ? "R7" : "R2");
    if (code == 0) return "R2";
    if (dx > lx)  return (code == 4) ? "R5" : ((code == 3 || code == 5 || code == 7 || code == 2) ? "R3" : "R12");
    return (code == 1 || code == 6 || code == 4 || code == 8 || code == 2) ? "R4" : "R12";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive after the falling edge, compare, then advance the model at the rising edge.
  task automatic step(bit v, bit h, bit t, int dx, int dy, bit we, int code, bit rdy, string tag);
    int exp_port;
    @(negedge clk);
    in_valid = v; in_head = h; in_tail = t;
    in_dest_x = 4'(dx); in_dest_y = 4'(dy);
    cfg_we = we; cfg_code = 4'(code); out_ready = rdy;
    #2;
    exp_port = m_flight ? m_lock : ref_route(m_cfg, int'(loc_x), int'(loc_y), dx, dy);
    check(out_valid == v && in_ready == rdy, "R1", {30'd0, out_valid, in_ready}, {v, rdy});
    if (v) check(out_sel == 5'(1 << exp_port), tag, int'(out_sel), 1 << exp_port);
    @(posedge clk);
    if (v && rdy) begin
      if (t) m_flight = 0;
      else if (!m_flight && h) begin m_flight = 1; m_lock = exp_port; end
    end
    if (we) m_cfg = code;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    loc_x = 4'd2; loc_y = 4'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, own address goes LOCAL
    step(1, 1, 1, 2, 2, 0, 0, 1, "R1");
    // R2: healthy X-first, several single-flit packets
    step(1, 1, 1, 3, 0, 0, 0, 1, "R2");
    step(1, 1, 1, 0, 3, 0, 0, 1, "R2");
    step(1, 1, 1, 2, 3, 0, 0, 1, "R2");
    step(1, 1, 1, 2, 0, 0, 0, 1, "R2");

    // Sweep all codes, local and destination positions (R2-R8, R12)
    for (int code = 0; code < 16; code++) begin
      step(0, 0, 0, 0, 0, 1, code, 1, "R11");
      for (int lx = 0; lx < 4; lx++)
        for (int ly = 0; ly < 4; ly++) begin
          @(negedge clk); loc_x = 4'(lx); loc_y = 4'(ly);
          for (int dx = 0; dx < 4; dx++)
            for (int dy = 0; dy < 4; dy++)
              step(1, 1, 1, dx, dy, 0, 0, 1, sweep_tag(code, lx, ly, dx, dy));
        end
    end

    // R9: multi-flit packet with stall, gap and changing body destinations
    step(0, 0, 0, 0, 0, 1, 0, 1, "R11");
    @(negedge clk); loc_x = 4'd1; loc_y = 4'd1;
    step(1, 1, 0, 3, 1, 0, 0, 1, "R9");   // EAST locked
    step(1, 0, 0, 0, 1, 0, 0, 0, "R9");   // stalled body
    step(0, 0, 0, 1, 3, 0, 0, 1, "R9");   // gap
    step(1, 0, 0, 1, 0, 0, 0, 1, "R9");
    step(1, 0, 1, 1, 1, 0, 0, 1, "R9");   // tail still EAST
    // R10: single-flit then a fresh first flit
    step(1, 1, 1, 0, 1, 0, 0, 1, "R10");  // WEST
    step(1, 1, 1, 1, 3, 0, 0, 1, "R10");  // NORTH

    // R11: code write mid-packet leaves packet alone, governs next head
    step(1, 1, 0, 1, 3, 0, 0, 1, "R11");  // NORTH locked
    step(1, 0, 0, 3, 3, 1, 2, 1, "R11");  // write S-of
    step(1, 0, 1, 1, 0, 0, 0, 1, "R11");  // tail still NORTH
    step(1, 1, 1, 1, 3, 0, 0, 1, "R11");  // S-of, column 1 -> WEST
    step(1, 1, 1, 2, 1, 1, 0, 1, "R11");  // write same cycle: old code, EAST
    step(1, 1, 1, 1, 3, 0, 0, 1, "R11");  // healthy again -> NORTH

    // R1: reset returns to healthy code and clears the lock
    step(1, 1, 0, 3, 1, 1, 4, 1, "R1");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_cfg = 0; m_flight = 0; m_lock = 0;
    step(1, 1, 1, 3, 3, 0, 0, 1, "R1");
    step(1, 1, 1, 1, 1, 0, 0, 1, "R1");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule